// File: doc/BRIEF.md
# Interval counter with limit compare

This block is the counting core of a programmable interval timer. A free-running count register advances by one on every tick pulse from an external timebase. The incremented value is compared with a software-loaded limit register for exact equality. When the two agree, the block records the event in a sticky limit flag. If the same event happens again before software has acknowledged the first one, a separate lost-tick flag is set instead. An optional auto-clear returns the count to zero on a match, so the block can generate periodic events. A one-cycle interrupt-request pulse is produced on a match when interrupts are enabled and the surrounding interrupt logic reports that no interrupt is already active.

Software reaches the block through a single write port. A select input decides whether the write loads the limit or zeroes the count. A synchronous master reset returns every register to zero. The two flags are held by a four-state machine. FL_IDLE means neither flag is set, FL_LIMIT means only the limit flag is set, FL_LOST means only the lost-tick flag is set, and FL_BOTH means both are set. In every state, the requested clears are applied first and a same-cycle match is then applied to the result. A match therefore takes FL_IDLE to FL_LIMIT, FL_LIMIT to FL_BOTH, and FL_LOST to FL_BOTH. Clearing the only set flag with no match returns to FL_IDLE. Clearing one flag of FL_BOTH with no match leaves the other flag's state.

Top module: `icl_interval_timer`

## Requirements
- R1: With no count clear and no master reset, a tick adds one to the count, modulo 2^CNT_W (65536 at the default width); with no tick the count holds.
- R2: A match is a tick whose incremented count equals the limit value held before that edge; equality is the only comparison, so a limit loaded below the current count matches only after the count wraps and climbs back up to it.
- R3: A match with the limit flag clear sets the limit flag; a match with the limit flag already set sets the lost-tick flag and leaves the limit flag set.
- R4: When auto_clr is 1, a matching tick leaves the count at 0 instead of the incremented value.
- R5: irq_req is 1 for exactly the cycle after a matching edge, and only if irq_en was 1 and irq_active was 0 at that edge; otherwise it is 0.
- R6: A write (wr_en=1) with wr_count_sel=1 sets the count to 0, ignores wr_data and leaves the limit unchanged; with wr_count_sel=0 it loads wr_data into the limit and leaves the count path alone.
- R7: A count clear in the same cycle as a tick wins: the count becomes 0 and no match is taken from that tick.
- R8: Each flag stays set until its own clear input is 1; a clear and a match in the same cycle apply the clear first, then the match.
- R9: mreset=1 zeroes the count, the limit, both flags and irq_req at the next edge, overriding every other input.
- R10: After rst_n is released, the count, both flags and irq_req are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mreset | input | 1 | Synchronous master reset |
| tick | input | 1 | Timebase tick, one cycle per period |
| wr_en | input | 1 | Register write strobe |
| wr_count_sel | input | 1 | 1: write zeroes the count; 0: write loads the limit |
| wr_data | input | CNT_W | Write data for the limit |
| auto_clr | input | 1 | Zero the count on a match |
| irq_en | input | 1 | Allow interrupt requests |
| irq_active | input | 1 | An interrupt is already being serviced |
| clr_limit_flag | input | 1 | Clear the limit flag |
| clr_lost_flag | input | 1 | Clear the lost-tick flag |
| count | output | CNT_W | Current count |
| limit_flag | output | 1 | Sticky limit-reached flag |
| lost_flag | output | 1 | Sticky lost-tick flag |
| irq_req | output | 1 | One-cycle interrupt request pulse |

## Verification
Every result is registered exactly once. The count, both flags and irq_req all show the effect of a stimulus one clock edge after the cycle in which it was presented, and no output has a second pipeline stage. The bench holds each stimulus over a rising edge and updates its arithmetic model at that edge. It then compares all four outputs one nanosecond later, so each comparison sees the edge that consumed the stimulus and no other. The limit register is never read back directly; its value is inferred from the cycle in which the flags and irq_req respond.

// File: rtl/icl_pkg.sv
package icl_pkg;

    // Flag pair state: {lost, limit}
    typedef enum logic [1:0] {
        FL_IDLE  = 2'b00,
        FL_LIMIT = 2'b01,
        FL_LOST  = 2'b10,
        FL_BOTH  = 2'b11
    } flag_state_e;

endpackage

// File: rtl/icl_count_reg.sv
module icl_count_reg #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mreset,
    input  logic             cnt_clr,
    input  logic             tick,
    input  logic             wrap_clr,
    output logic [CNT_W-1:0] count_q,
    output logic [CNT_W-1:0] count_inc
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    assign count_inc = count_q + ONE;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (mreset || cnt_clr) begin
            count_q <= '0;
        end else if (tick) begin
            count_q <= wrap_clr ? '0 : count_inc;
        end
    end

endmodule

// File: rtl/icl_limit_cmp.sv
module icl_limit_cmp #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mreset,
    input  logic             ld_en,
    input  logic [CNT_W-1:0] ld_data,
    input  logic [CNT_W-1:0] cand,
    output logic [CNT_W-1:0] limit_q,
    output logic             equal
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            limit_q <= '0;
        end else if (mreset) begin
            limit_q <= '0;
        end else if (ld_en) begin
            limit_q <= ld_data;
        end
    end

    assign equal = (cand == limit_q);

endmodule

// File: rtl/icl_flag_fsm.sv
module icl_flag_fsm
    import icl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mreset,
    input  logic match,
    input  logic clr_lim,
    input  logic clr_lost,
    input  logic irq_en,
    input  logic irq_active,
    output logic limit_flag,
    output logic lost_flag,
    output logic irq_req
);

    flag_state_e state_q, state_d;
    logic        irq_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FL_IDLE;
            irq_q   <= 1'b0;
        end else if (mreset) begin
            state_q <= FL_IDLE;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            irq_q   <= match && irq_en && !irq_active;
        end
    end

    // Next state: clears first, then a match
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_IDLE: begin
                if (match) state_d = FL_LIMIT;
            end
            FL_LIMIT: begin
                if (clr_lim) state_d = match ? FL_LIMIT : FL_IDLE;
                else         state_d = match ? FL_BOTH  : FL_LIMIT;
            end
            FL_LOST: begin
                if (clr_lost) state_d = match ? FL_LIMIT : FL_IDLE;
                else          state_d = match ? FL_BOTH  : FL_LOST;
            end
            FL_BOTH: begin
                if (clr_lim && clr_lost) state_d = match ? FL_LIMIT : FL_IDLE;
                else if (clr_lim)        state_d = match ? FL_BOTH  : FL_LOST;
                else if (clr_lost)       state_d = match ? FL_BOTH  : FL_LIMIT;
                else                     state_d = FL_BOTH;
            end
            default: state_d = FL_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        limit_flag = 1'b0;
        lost_flag  = 1'b0;
        unique case (state_q)
            FL_IDLE:  ;
            FL_LIMIT: limit_flag = 1'b1;
            FL_LOST:  lost_flag  = 1'b1;
            FL_BOTH: begin
                limit_flag = 1'b1;
                lost_flag  = 1'b1;
            end
            default: ;
        endcase
        irq_req = irq_q;
    end

endmodule

// File: rtl/icl_interval_timer.sv
module icl_interval_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mreset,
    input  logic             tick,
    input  logic             wr_en,
    input  logic             wr_count_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             auto_clr,
    input  logic             irq_en,
    input  logic             irq_active,
    input  logic             clr_limit_flag,
    input  logic             clr_lost_flag,
    output logic [CNT_W-1:0] count,
    output logic             limit_flag,
    output logic             lost_flag,
    output logic             irq_req
);

    logic             cnt_clr;
    logic             ld_en;
    logic             equal;
    logic             match;
    logic [CNT_W-1:0] count_inc;
    logic [CNT_W-1:0] limit_q;

    assign cnt_clr = wr_en && wr_count_sel;
    assign ld_en   = wr_en && !wr_count_sel;
    assign match   = tick && !cnt_clr && equal;

    icl_count_reg #(.CNT_W(CNT_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .mreset    (mreset),
        .cnt_clr   (cnt_clr),
        .tick      (tick),
        .wrap_clr  (match && auto_clr),
        .count_q   (count),
        .count_inc (count_inc)
    );

    icl_limit_cmp #(.CNT_W(CNT_W)) u_limit (
        .clk     (clk),
        .rst_n   (rst_n),
        .mreset  (mreset),
        .ld_en   (ld_en),
        .ld_data (wr_data),
        .cand    (count_inc),
        .limit_q (limit_q),
        .equal   (equal)
    );

    icl_flag_fsm u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .mreset     (mreset),
        .match      (match),
        .clr_lim    (clr_limit_flag),
        .clr_lost   (clr_lost_flag),
        .irq_en     (irq_en),
        .irq_active (irq_active),
        .limit_flag (limit_flag),
        .lost_flag  (lost_flag),
        .irq_req    (irq_req)
    );

endmodule

// File: rtl/icl_interval_timer_chk.sv
module icl_interval_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mreset,
    input logic             tick,
    input logic             wr_en,
    input logic             wr_count_sel,
    input logic             auto_clr,
    input logic             irq_en,
    input logic             irq_active,
    input logic             clr_limit_flag,
    input logic             clr_lost_flag,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] limit_val,
    input logic             limit_flag,
    input logic             lost_flag,
    input logic             irq_req
);

    // R1
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !mreset && !(wr_en && wr_count_sel) && !auto_clr)
        |=> count == $past(count) + CNT_W'(1));

    // R4
    auto_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !mreset && !(wr_en && wr_count_sel) && auto_clr &&
         (count + CNT_W'(1) == limit_val))
        |=> count == '0);

    // R7
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_count_sel) |=> count == '0);

    // R3
    lost_needs_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lost_flag) |-> $past(limit_flag));

    // R5
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> ($past(irq_en) && !$past(irq_active)));

    // R8
    limit_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (limit_flag && !clr_limit_flag && !mreset) |=> limit_flag);

    // R8
    lost_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lost_flag && !clr_lost_flag && !mreset) |=> lost_flag);

    // R9
    master_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mreset |=> (count == '0 && limit_val == '0 && !limit_flag && !lost_flag && !irq_req));

endmodule

bind icl_interval_timer icl_interval_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .mreset         (mreset),
    .tick           (tick),
    .wr_en          (wr_en),
    .wr_count_sel   (wr_count_sel),
    .auto_clr       (auto_clr),
    .irq_en         (irq_en),
    .irq_active     (irq_active),
    .clr_limit_flag (clr_limit_flag),
    .clr_lost_flag  (clr_lost_flag),
    .count          (count),
    .limit_val      (limit_q),
    .limit_flag     (limit_flag),
    .lost_flag      (lost_flag),
    .irq_req        (irq_req)
);

// File: tb/tb_icl_interval_timer.sv
`timescale 1ns/100ps
module tb_icl_interval_timer;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mreset = 1'b0;
    logic         tick = 1'b0;
    logic         wr_en = 1'b0;
    logic         wr_count_sel = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         auto_clr = 1'b0;
    logic         irq_en = 1'b0;
    logic         irq_active = 1'b0;
    logic         clr_limit_flag = 1'b0;
    logic         clr_lost_flag = 1'b0;
    logic [W-1:0] count;
    logic         limit_flag, lost_flag, irq_req;

    int checks = 0;
    int errors = 0;

    // bench model
    logic [W-1:0] m_count = '0;
    logic [W-1:0] m_limit = '0;
    logic         m_lim = 1'b0;
    logic         m_lost = 1'b0;
    logic         m_irq = 1'b0;

    always #2.5 clk = ~clk;

    icl_interval_timer #(.CNT_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .mreset(mreset), .tick(tick),
        .wr_en(wr_en), .wr_count_sel(wr_count_sel), .wr_data(wr_data),
        .auto_clr(auto_clr), .irq_en(irq_en), .irq_active(irq_active),
        .clr_limit_flag(clr_limit_flag), .clr_lost_flag(clr_lost_flag),
        .count(count), .limit_flag(limit_flag), .lost_flag(lost_flag),
        .irq_req(irq_req)
    );

    task automatic idle_inputs();
        mreset = 0; tick = 0; wr_en = 0; wr_count_sel = 0; wr_data = '0;
        clr_limit_flag = 0; clr_lost_flag = 0;
    endtask

    task automatic step(input string tag);
        logic [W-1:0] nxt;
        logic         cclr, hit, l, o;
        @(posedge clk);
        if (!rst_n || mreset) begin
            m_count = '0; m_limit = '0; m_lim = 0; m_lost = 0; m_irq = 0;
        end else begin
            cclr = wr_en && wr_count_sel;
            nxt  = m_count + W'(1);
            hit  = tick && !cclr && (nxt == m_limit);
            l = m_lim && !clr_limit_flag;
            o = m_lost && !clr_lost_flag;
            if (hit) begin
                if (l) o = 1'b1;
                else   l = 1'b1;
            end
            m_lim = l; m_lost = o;
            m_irq = hit && irq_en && !irq_active;
            if (cclr)      m_count = '0;
            else if (tick) m_count = (hit && auto_clr) ? '0 : nxt;
            if (wr_en && !wr_count_sel) m_limit = wr_data;
        end
        #1;
        checks++;
        if (count !== m_count || limit_flag !== m_lim || lost_flag !== m_lost || irq_req !== m_irq) begin
            errors++;
            $display("FAIL %s actual count=%0d lim=%b lost=%b irq=%b expected count=%0d lim=%b lost=%b irq=%b",
                     tag, count, limit_flag, lost_flag, irq_req, m_count, m_lim, m_lost, m_irq);
        end
    endtask

    task automatic ticks(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            tick = 1; step(tag);
        end
        tick = 0;
    endtask

    task automatic load_limit(input logic [W-1:0] v);
        wr_en = 1; wr_count_sel = 0; wr_data = v; step("R6");
        wr_en = 0;
    endtask

    task automatic do_mreset();
        mreset = 1; step("R9"); mreset = 0;
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog R10 actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle_inputs();
        // R10: reset state
        step("R10"); step("R10");
        rst_n = 1;
        step("R10");

        // Sweep: every limit, both auto-clear settings (R1 R2 R3 R4 R5 R8)
        for (int lim = 0; lim < 16; lim++) begin
            for (int ac = 0; ac < 2; ac++) begin
                do_mreset();
                auto_clr = ac[0];
                irq_en = 1;
                load_limit(W'(lim));
                for (int k = 0; k < 40; k++) begin
                    tick = (k % 5 != 4);
                    irq_active = (k % 7 == 3);
                    clr_limit_flag = (k % 13 == 12);
                    clr_lost_flag = (k % 17 == 16);
                    step(ac ? "R4" : "R3");
                end
                idle_inputs(); irq_active = 0;
                step("R1");
            end
        end

        // R2: limit below count, match only after wrap
        auto_clr = 0; irq_en = 1;
        do_mreset();
        ticks(10, "R1");
        load_limit(W'(4));
        ticks(9, "R2");
        ticks(1, "R2");
        step("R2");

        // R7: count clear beats tick; R6: data ignored on count clear
        do_mreset();
        load_limit(W'(5));
        ticks(4, "R1");
        tick = 1; wr_en = 1; wr_count_sel = 1; wr_data = W'(3); step("R7");
        idle_inputs();
        ticks(3, "R6");
        ticks(2, "R6");
        step("R6");

        // R8: clear in same cycle as match; lost flag path
        do_mreset();
        load_limit(W'(2));
        auto_clr = 1;
        ticks(2, "R3");
        ticks(2, "R3");
        tick = 1; ticks(1, "R8");
        tick = 1; clr_limit_flag = 1; step("R8");
        idle_inputs();
        tick = 1; clr_limit_flag = 1; clr_lost_flag = 1; step("R8");
        idle_inputs();
        for (int k = 0; k < 6; k++) step("R8");

        // R5: interrupt gating
        irq_en = 0; ticks(4, "R5");
        irq_en = 1; irq_active = 1; ticks(4, "R5");
        irq_active = 0; ticks(4, "R5");

        // R9: master reset overrides tick and write
        tick = 1; wr_en = 1; wr_data = W'(7); mreset = 1; step("R9");
        idle_inputs();
        ticks(20, "R9");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule